// File: doc/BRIEF.md
# Block Load/Store Transfer Sequencer

This block steps through the register list of a block load or block store and hands the memory side up to two register transfers per cycle over a 64-bit data path. A start strobe captures a register mask, a word-aligned base address and the transfer direction. From the next cycle on, the block presents one or two transfer slots per cycle. Each slot carries a register index and a byte address. Registers are taken lowest index first, and each one advances the address by 4 bytes. Memory is assumed to accept every transfer in the cycle it is offered.

Two registers share a cycle only when the slot address sits on a doubleword boundary (address bit 2 clear). An odd-word base therefore starts with a lone transfer, and pairs follow from then on. The block keeps a pending vector with one bit per register that is still to be moved. Issue logic outside the block can stall a later instruction on just the registers it needs, and release it as soon as those registers have moved instead of waiting for the whole list. When the list is exhausted the block pulses done once. It also holds the written-back base, which is the start address plus 4 times the number of listed registers.

Top module: `lsm_seq`

## Requirements
- R1: After reset, busy_o, done_o, s0_vld_o and s1_vld_o are 0 and pend_o is all zero. No slot is valid while busy_o is 0.
- R2: A start_i seen at a clock edge while busy_o is 0 captures mask_i, base_i and load_i. In the following cycle pend_o equals the captured mask, and busy_o is 1 if the mask is non-zero. A start_i seen while busy_o is 1 is ignored and has no effect on the running sequence or on wb_addr_o.
- R3: Slot 0 carries the lowest-numbered register still pending. Slot 1, when valid, carries the next-lowest one. The slot 0 address of the first busy cycle equals the captured base. Every register advances the address by 4, and the slot 1 address equals the slot 0 address plus 4.
- R4: Slot 1 is valid only when the slot 0 address has bit 2 equal to 0 and at least two registers are pending. Under those conditions it is always valid.
- R5: For n listed registers, a base with bit 2 clear takes ceil(n/2) busy cycles. A base with bit 2 set takes 1 + ceil((n-1)/2) busy cycles. For an aligned base, lists of 2k-1 and 2k registers take the same count.
- R6: A register's pend_o bit drops in the cycle right after the cycle in which it was presented in a slot. Bits are never set during a sequence.
- R7: done_o is 1 for exactly one cycle: the cycle after the last transfer cycle. In that cycle busy_o is 0 and pend_o is zero.
- R8: From the cycle after an accepted start, wb_addr_o holds the captured base plus 4 times the number of set bits in the captured mask.
- R9: An accepted start with an all-zero mask produces no transfers, and done_o rises in the next cycle.
- R10: While busy_o is 1, load_o equals the captured direction (1 for a load, 0 for a store).

Top module port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted only while idle |
| mask_i | input | NREG (16) | Register list, bit i selects register i |
| base_i | input | AW (32) | Word-aligned base byte address |
| load_i | input | 1 | Direction: 1 load, 0 store |
| busy_o | output | 1 | Sequence in progress |
| s0_vld_o | output | 1 | Slot 0 transfer valid |
| s0_reg_o | output | IW (4) | Slot 0 register index |
| s0_addr_o | output | AW (32) | Slot 0 byte address |
| s1_vld_o | output | 1 | Slot 1 transfer valid |
| s1_reg_o | output | IW (4) | Slot 1 register index |
| s1_addr_o | output | AW (32) | Slot 1 byte address |
| load_o | output | 1 | Captured direction |
| pend_o | output | NREG (16) | Registers not yet transferred |
| done_o | output | 1 | One-cycle completion pulse |
| wb_addr_o | output | AW (32) | Written-back base address |

## Verification
The assertions assume that base_i has its two low bits clear, because the pairing rule and the plus-4 and plus-8 address steps only make sense for word addresses. They also assume the memory side never refuses a slot, since the block has no stall input. Every base address in the stimulus is a multiple of 4, and the set mixes odd and even doubleword alignment. The stimulus also drives start_i in the middle of a running sequence, to show that the ordering and pending properties hold through an ignored request.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  localparam int NREG_DEF = 16;
  localparam int AW_DEF   = 32;
  localparam int WORD_B   = 4;
  localparam int PAIR_B   = 2 * WORD_B;
endpackage

// File: rtl/lsm_pick.sv
module lsm_pick #(
  parameter int NREG = lsm_pkg::NREG_DEF,
  localparam int IW  = $clog2(NREG)
) (
  input  logic [NREG-1:0] rem_i,
  input  logic            pair_ok_i,
  output logic            v0_o,
  output logic [IW-1:0]   i0_o,
  output logic            v1_o,
  output logic [IW-1:0]   i1_o,
  output logic [NREG-1:0] take_o
);
  function automatic logic [IW-1:0] low_idx(input logic [NREG-1:0] m);
    logic [IW-1:0] r;
    r = '0;
    for (int k = NREG - 1; k >= 0; k--)
      if (m[k]) r = IW'(k);
    return r;
  endfunction

  logic [NREG-1:0] one0, rest;
  logic [NREG-1:0] one1;

  always_comb begin
    v0_o   = |rem_i;
    i0_o   = low_idx(rem_i);
    one0   = v0_o ? (NREG'(1) << i0_o) : '0;
    rest   = rem_i & ~one0;
    v1_o   = pair_ok_i && (|rest);
    i1_o   = low_idx(rest);
    one1   = v1_o ? (NREG'(1) << i1_o) : '0;
    take_o = one0 | one1;
  end
endmodule

// File: rtl/lsm_addr.sv
module lsm_addr #(
  parameter int AW = lsm_pkg::AW_DEF
) (
  input  logic [AW-1:0] cur_i,
  input  logic          two_i,
  output logic [AW-1:0] a0_o,
  output logic [AW-1:0] a1_o,
  output logic [AW-1:0] nxt_o
);
  function automatic logic [AW-1:0] step(input logic [AW-1:0] a, input logic two);
    return a + (two ? AW'(lsm_pkg::PAIR_B) : AW'(lsm_pkg::WORD_B));
  endfunction

  assign a0_o  = cur_i;
  assign a1_o  = cur_i + AW'(lsm_pkg::WORD_B);
  assign nxt_o = step(cur_i, two_i);
endmodule

// File: rtl/lsm_seq.sv
module lsm_seq #(
  parameter int NREG = lsm_pkg::NREG_DEF,
  parameter int AW   = lsm_pkg::AW_DEF,
  localparam int IW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [NREG-1:0] mask_i,
  input  logic [AW-1:0]   base_i,
  input  logic            load_i,
  output logic            busy_o,
  output logic            s0_vld_o,
  output logic [IW-1:0]   s0_reg_o,
  output logic [AW-1:0]   s0_addr_o,
  output logic            s1_vld_o,
  output logic [IW-1:0]   s1_reg_o,
  output logic [AW-1:0]   s1_addr_o,
  output logic            load_o,
  output logic [NREG-1:0] pend_o,
  output logic            done_o,
  output logic [AW-1:0]   wb_addr_o
);
  function automatic logic [AW-1:0] wb_calc(input logic [AW-1:0] b, input logic [NREG-1:0] m);
    logic [AW-1:0] n;
    n = '0;
    for (int k = 0; k < NREG; k++) n = n + AW'(m[k]);
    return b + (n << 2);
  endfunction

  logic            active_q, done_q, load_q;
  logic [NREG-1:0] rem_q;
  logic [AW-1:0]   cur_q, wb_q;

  logic            v0, v1;
  logic [IW-1:0]   i0, i1;
  logic [NREG-1:0] take, rem_nx;
  logic [AW-1:0]   a0, a1, cur_nx;
  logic            accept, pair_ok, last_step;

  assign accept    = start_i && !active_q;
  assign pair_ok   = !cur_q[2];
  assign rem_nx    = rem_q & ~take;
  assign last_step = active_q && (rem_nx == '0);

  lsm_pick #(.NREG(NREG)) u_pick (
    .rem_i(rem_q), .pair_ok_i(pair_ok),
    .v0_o(v0), .i0_o(i0), .v1_o(v1), .i1_o(i1), .take_o(take)
  );

  lsm_addr #(.AW(AW)) u_addr (
    .cur_i(cur_q), .two_i(v1), .a0_o(a0), .a1_o(a1), .nxt_o(cur_nx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      load_q   <= 1'b0;
      rem_q    <= '0;
      cur_q    <= '0;
      wb_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        rem_q    <= mask_i;
        cur_q    <= base_i;
        load_q   <= load_i;
        wb_q     <= wb_calc(base_i, mask_i);
        active_q <= |mask_i;
        done_q   <= ~|mask_i;
      end else if (active_q) begin
        rem_q <= rem_nx;
        cur_q <= cur_nx;
        if (last_step) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end
      end
    end
  end

  assign busy_o    = active_q;
  assign s0_vld_o  = active_q && v0;
  assign s0_reg_o  = i0;
  assign s0_addr_o = a0;
  assign s1_vld_o  = active_q && v1;
  assign s1_reg_o  = i1;
  assign s1_addr_o = a1;
  assign load_o    = load_q;
  assign pend_o    = rem_q;
  assign done_o    = done_q;
  assign wb_addr_o = wb_q;
endmodule

// File: rtl/lsm_seq_chk.sv
module lsm_seq_chk #(
  parameter int NREG = 16,
  parameter int AW   = 32,
  localparam int IW  = $clog2(NREG)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy_o,
  input logic            s0_vld_o,
  input logic [IW-1:0]   s0_reg_o,
  input logic [AW-1:0]   s0_addr_o,
  input logic            s1_vld_o,
  input logic [IW-1:0]   s1_reg_o,
  input logic [AW-1:0]   s1_addr_o,
  input logic [NREG-1:0] pend_o,
  input logic            done_o
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!s0_vld_o && !s1_vld_o));

  p_pair_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld_o |-> (s1_reg_o > s0_reg_o) && (s1_addr_o == s0_addr_o + AW'(4)));

  p_pair_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld_o |-> (s0_vld_o && !s0_addr_o[2]));

  p_pend_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    s0_vld_o |=> !pend_o[$past(s0_reg_o)]);

  p_pend_no_new_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> ((pend_o & ~$past(pend_o)) == '0));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && (pend_o == '0)));
endmodule

bind lsm_seq lsm_seq_chk #(.NREG(NREG), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o),
  .s0_vld_o(s0_vld_o), .s0_reg_o(s0_reg_o), .s0_addr_o(s0_addr_o),
  .s1_vld_o(s1_vld_o), .s1_reg_o(s1_reg_o), .s1_addr_o(s1_addr_o),
  .pend_o(pend_o), .done_o(done_o)
);

// File: tb/sim_lsm_seq.sv
module sim_lsm_seq;
  localparam int CLK_P = 10;
  localparam int NV    = 9;

  typedef struct packed {
    logic [15:0] mask;
    logic [31:0] base;
    logic [7:0]  cyc;
    logic [31:0] wb;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{16'h000F, 32'h0000_0100, 8'd2, 32'h0000_0110},
    '{16'h000F, 32'h0000_0104, 8'd3, 32'h0000_0114},
    '{16'h0007, 32'h0000_0200, 8'd2, 32'h0000_020C},
    '{16'h0007, 32'h0000_0204, 8'd2, 32'h0000_0210},
    '{16'h8001, 32'h0000_1000, 8'd1, 32'h0000_1008},
    '{16'hFFFF, 32'h0000_0000, 8'd8, 32'h0000_0040},
    '{16'hFFFF, 32'h0000_0004, 8'd9, 32'h0000_0044},
    '{16'h0400, 32'h0000_030C, 8'd1, 32'h0000_0310},
    '{16'hA5A5, 32'h0000_2000, 8'd4, 32'h0000_2020}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] mask_i = '0;
  logic [31:0] base_i = '0;
  logic        load_i = 1'b0;
  logic        busy_o, s0_vld_o, s1_vld_o, load_o, done_o;
  logic [3:0]  s0_reg_o, s1_reg_o;
  logic [31:0] s0_addr_o, s1_addr_o, wb_addr_o;
  logic [15:0] pend_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_P / 2) clk = ~clk;

  lsm_seq u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mask_i(mask_i),
    .base_i(base_i), .load_i(load_i), .busy_o(busy_o),
    .s0_vld_o(s0_vld_o), .s0_reg_o(s0_reg_o), .s0_addr_o(s0_addr_o),
    .s1_vld_o(s1_vld_o), .s1_reg_o(s1_reg_o), .s1_addr_o(s1_addr_o),
    .load_o(load_o), .pend_o(pend_o), .done_o(done_o), .wb_addr_o(wb_addr_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [15:0] m, input logic [31:0] b, input logic ld,
                     input logic [7:0] ecyc, input logic [31:0] ewb, input int inj);
    logic [15:0] rem;
    logic [31:0] a;
    int cyc;
    int lo, hi, cnt;
    bit two;
    @(negedge clk);
    start_i = 1'b1; mask_i = m; base_i = b; load_i = ld;
    @(negedge clk);
    start_i = 1'b0;
    rem = m; a = b; cyc = 0;
    chk(pend_o == m, "R2 pend after start", {16'h0, pend_o}, {16'h0, m});
    chk(busy_o == (m != 0), "R2 busy after start", {31'h0, busy_o}, {31'h0, (m != 0)});
    while (busy_o && cyc < 40) begin
      lo = -1; hi = -1; cnt = 0;
      for (int k = 0; k < 16; k++) begin
        if (rem[k]) begin
          cnt++;
          if (lo < 0) lo = k;
          else if (hi < 0) hi = k;
        end
      end
      two = (a[2] == 1'b0) && (cnt >= 2);
      chk(s0_vld_o && (s0_reg_o == 4'(lo)), "R3 slot0 reg", {28'h0, s0_reg_o}, 32'(lo));
      chk(s0_addr_o == a, "R3 slot0 addr", s0_addr_o, a);
      chk(s1_vld_o == two, "R4 slot1 valid", {31'h0, s1_vld_o}, {31'h0, two});
      if (two) begin
        chk(s1_reg_o == 4'(hi), "R3 slot1 reg", {28'h0, s1_reg_o}, 32'(hi));
        chk(s1_addr_o == a + 32'd4, "R3 slot1 addr", s1_addr_o, a + 32'd4);
      end
      chk(pend_o == rem, "R6 pending vector", {16'h0, pend_o}, {16'h0, rem});
      chk(load_o == ld, "R10 direction", {31'h0, load_o}, {31'h0, ld});
      rem[lo] = 1'b0;
      if (two) begin rem[hi] = 1'b0; a = a + 32'd8; end
      else a = a + 32'd4;
      cyc++;
      if (cyc == inj) begin
        start_i = 1'b1; mask_i = 16'h0001; base_i = 32'h0000_0500; load_i = ~ld;
      end
      @(negedge clk);
      start_i = 1'b0;
    end
    chk(cyc == int'(ecyc), "R5 cycle count", 32'(cyc), {24'h0, ecyc});
    chk(done_o == 1'b1, "R7 done pulse", {31'h0, done_o}, 32'h1);
    chk(pend_o == 16'h0, "R7 pending clear", {16'h0, pend_o}, 32'h0);
    chk(wb_addr_o == ewb, "R8 writeback", wb_addr_o, ewb);
    @(negedge clk);
    chk(done_o == 1'b0, "R7 done one cycle", {31'h0, done_o}, 32'h0);
  endtask

  initial begin
    #(CLK_P * 50000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !s0_vld_o && !s1_vld_o, "R1 reset outputs",
        {28'h0, busy_o, done_o, s0_vld_o, s1_vld_o}, 32'h0);
    chk(pend_o == 16'h0, "R1 reset pending", {16'h0, pend_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++)
      run(VEC[i].mask, VEC[i].base, logic'(i % 2), VEC[i].cyc, VEC[i].wb, -1);

    // R2: start during a running sequence is ignored
    run(16'hFFFF, 32'h0000_0000, 1'b1, 8'd8, 32'h0000_0040, 2);

    // R9: empty list finishes at once with no transfer
    run(16'h0000, 32'h0000_0700, 1'b0, 8'd0, 32'h0000_0700, -1);
    chk(!s0_vld_o && !busy_o, "R9 no transfer", {30'h0, s0_vld_o, busy_o}, 32'h0);

    // R5: aligned 2k-1 and 2k lists take equal cycles
    run(16'h001F, 32'h0000_0040, 1'b0, 8'd3, 32'h0000_0054, -1);
    run(16'h003F, 32'h0000_0040, 1'b0, 8'd3, 32'h0000_0058, -1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule